// File: doc/BRIEF.md
# BCH(15,5) Syndrome Calculator

This block is the front stage of a decoder for the binary BCH code of length 15 with 5 data bits, which corrects up to three bit errors. It takes the received word one bit per clock and evaluates it at the field elements alpha^1 to alpha^6 of GF(16). The results, six 4-bit syndromes, are what a key-equation solver needs to locate errors. If every syndrome is zero, the word is a valid codeword.

Only the odd syndromes S1, S3 and S5 have their own running accumulators. Each accumulator multiplies by a constant power of alpha and adds the incoming bit. The even syndromes come from the odd ones through a fixed squaring network: S2 is S1 squared, S4 is S2 squared, and S6 is S3 squared.

A synchronous reset aligns the block to a codeword boundary. After that, frames of 15 bits follow each other with no gap. At the end of each frame the block raises a one-cycle completion pulse. With the pulse it updates the six syndrome outputs and an all-zero flag, and these outputs keep their values until the next frame completes.

Top module: `bch15_syndrome`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears its frame position, `done`, `all_zero` and all six syndrome outputs to zero. The next edge with `rst` low samples the first bit of a new frame.
- R2: Bits are taken MSB first. The first bit sampled in a frame is the coefficient r14 of x^14 and the fifteenth is r0. `syn1` equals r(alpha) in GF(16) built on x^4 + x + 1, where alpha is the root of that polynomial. Bit k of each 4-bit syndrome is the coefficient of alpha^k.
- R3: `syn3` equals r(alpha^3) and `syn5` equals r(alpha^5), using the same field, bit order and encoding as R2.
- R4: `syn2` equals `syn1` squared, `syn4` equals `syn2` squared, and `syn6` equals `syn3` squared, all in GF(16).
- R5: `done` is high for exactly one cycle. It is high in the cycle that follows the rising edge that samples the fifteenth bit of a frame, and at no other time.
- R6: Frames run back to back. The bit sampled at the edge after a frame's fifteenth bit is r14 of the next frame.
- R7: When `done` is high, `all_zero` is high exactly when all six syndromes are zero. For any valid codeword, such as the all-ones word, `all_zero` is high.
- R8: Between `done` pulses, with no reset, the syndrome outputs and `all_zero` keep the values they took at the last `done`.
- R9: A reset in the middle of a frame discards the partial frame. No `done` is raised for it, and the next complete frame's syndromes depend only on that frame's bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset and frame alignment |
| bit_in | input | 1 | Received bit, sampled on every rising edge when `rst` is low |
| done | output | 1 | One-cycle pulse: a frame's syndromes are ready |
| all_zero | output | 1 | High when all six syndromes of the last frame are zero |
| syn1 | output | 4 | S1 = r(alpha) |
| syn2 | output | 4 | S2 = r(alpha^2) |
| syn3 | output | 4 | S3 = r(alpha^3) |
| syn4 | output | 4 | S4 = r(alpha^4) |
| syn5 | output | 4 | S5 = r(alpha^5) |
| syn6 | output | 4 | S6 = r(alpha^6) |

## Verification
Every result of a frame is due one cycle after the rising edge that samples its fifteenth bit. At that point `done`, the six syndromes and `all_zero` change together, and no output moves between frames. The bench drives bits at falling edges and samples outputs 2 ns after each rising edge. Each `done` is therefore compared against the expected value queued when that frame was driven, and every other post-edge sample must match the last result, or zero after a reset. Frames are driven with no idle gap, so any off-by-one in the frame position shows up both as a mismatched queue entry and as a `done` at the wrong edge.

// File: rtl/bch15_syndrome.sv
module bch15_syndrome (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_in,
  output logic       done,
  output logic       all_zero,
  output logic [3:0] syn1,
  output logic [3:0] syn2,
  output logic [3:0] syn3,
  output logic [3:0] syn4,
  output logic [3:0] syn5,
  output logic [3:0] syn6
);
  localparam int M = 4;
  localparam int N = (1 << M) - 1;
  localparam logic [M-1:0] POLY_LOW = 4'b0011;

  function automatic logic [M-1:0] times_alpha(input logic [M-1:0] x);
    return {x[M-2:0], 1'b0} ^ (x[M-1] ? POLY_LOW : '0);
  endfunction

  function automatic logic [M-1:0] times_alpha_pow(input logic [M-1:0] x, input int e);
    logic [M-1:0] r;
    r = x;
    for (int i = 0; i < e; i++) r = times_alpha(r);
    return r;
  endfunction

  function automatic logic [M-1:0] sq(input logic [M-1:0] a);
    return {a[3], a[1] ^ a[3], a[2], a[0] ^ a[2]};
  endfunction

  logic [M-1:0] pos;
  logic [M-1:0] acc1, acc3, acc5;
  logic [M-1:0] nxt1, nxt3, nxt5;
  logic         last;

  assign last = (pos == M'(N - 1));
  assign nxt1 = times_alpha_pow(acc1, 1) ^ {{(M-1){1'b0}}, bit_in};
  assign nxt3 = times_alpha_pow(acc3, 3) ^ {{(M-1){1'b0}}, bit_in};
  assign nxt5 = times_alpha_pow(acc5, 5) ^ {{(M-1){1'b0}}, bit_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      pos      <= '0;
      acc1     <= '0;
      acc3     <= '0;
      acc5     <= '0;
      done     <= 1'b0;
      all_zero <= 1'b0;
      syn1     <= '0;
      syn2     <= '0;
      syn3     <= '0;
      syn4     <= '0;
      syn5     <= '0;
      syn6     <= '0;
    end else begin
      done <= last;
      if (last) begin
        pos      <= '0;
        acc1     <= '0;
        acc3     <= '0;
        acc5     <= '0;
        syn1     <= nxt1;
        syn2     <= sq(nxt1);
        syn3     <= nxt3;
        syn4     <= sq(sq(nxt1));
        syn5     <= nxt5;
        syn6     <= sq(nxt3);
        all_zero <= (nxt1 == '0) && (nxt3 == '0) && (nxt5 == '0);
      end else begin
        pos  <= pos + 1'b1;
        acc1 <= nxt1;
        acc3 <= nxt3;
        acc5 <= nxt5;
      end
    end
  end
endmodule

// File: rtl/bch15_syndrome_chk.sv
module bch15_syndrome_chk (
  input logic       clk,
  input logic       rst,
  input logic       done,
  input logic       all_zero,
  input logic [3:0] syn1,
  input logic [3:0] syn2,
  input logic [3:0] syn3,
  input logic [3:0] syn4,
  input logic [3:0] syn5,
  input logic [3:0] syn6
);
  function automatic logic [3:0] fsq(input logic [3:0] a);
    logic [3:0] p;
    p = 4'h0;
    for (int i = 3; i >= 0; i--) begin
      p = {p[2:0], 1'b0} ^ (p[3] ? 4'h3 : 4'h0);
      if (a[i]) p = p ^ a;
    end
    return p;
  endfunction

  logic [4:0] since;
  always_ff @(posedge clk) begin
    if (rst)              since <= '0;
    else if (done)        since <= 5'd1;
    else if (since != '1) since <= since + 1'b1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done && !all_zero && {syn1, syn2, syn3, syn4, syn5, syn6} == '0)); // R1
  AST_DONE_SPACING: assert property (@(posedge clk) disable iff (rst)
    done |-> since == 5'd15); // R5
  AST_FRAME_END: assert property (@(posedge clk) disable iff (rst)
    since == 5'd15 |-> done); // R6
  AST_EVEN_SQUARES: assert property (@(posedge clk) disable iff (rst)
    done |-> (syn2 == fsq(syn1) && syn4 == fsq(syn2) && syn6 == fsq(syn3))); // R4
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    done |-> all_zero == ({syn1, syn2, syn3, syn4, syn5, syn6} == '0)); // R7
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> $stable({all_zero, syn1, syn2, syn3, syn4, syn5, syn6})); // R8
endmodule

bind bch15_syndrome bch15_syndrome_chk u_chk (
  .clk(clk), .rst(rst), .done(done), .all_zero(all_zero),
  .syn1(syn1), .syn2(syn2), .syn3(syn3), .syn4(syn4), .syn5(syn5), .syn6(syn6)
);

// File: tb/tb_bch15_syndrome.sv
module tb_bch15_syndrome;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic done, all_zero;
  logic [3:0] syn1, syn2, syn3, syn4, syn5, syn6;

  bch15_syndrome dut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .done(done), .all_zero(all_zero),
    .syn1(syn1), .syn2(syn2), .syn3(syn3), .syn4(syn4), .syn5(syn5), .syn6(syn6)
  );

  always #5 clk = ~clk;

  int errs = 0;
  int checks = 0;
  logic [24:0] expq[$];
  logic [24:0] last_seen = '0;
  logic [24:0] obs;
  logic [24:0] want;

  function automatic logic [3:0] gmul(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] p;
    p = 4'h0;
    for (int i = 3; i >= 0; i--) begin
      p = {p[2:0], 1'b0} ^ (p[3] ? 4'h3 : 4'h0);
      if (b[i]) p = p ^ a;
    end
    return p;
  endfunction

  function automatic logic [3:0] gpow(input int e);
    logic [3:0] r;
    r = 4'h1;
    for (int i = 0; i < e; i++) r = gmul(r, 4'h2);
    return r;
  endfunction

  function automatic logic [24:0] expect_of(input logic [14:0] w);
    logic [24:0] v;
    logic [3:0]  s;
    v = '0;
    for (int j = 1; j <= 6; j++) begin
      s = 4'h0;
      for (int i = 0; i < 15; i++) if (w[i]) s = s ^ gpow(i * j);
      v[(j-1)*4 +: 4] = s;
    end
    v[24] = (v[23:0] == '0);
    return v;
  endfunction

  function automatic logic [14:0] cw(input logic [4:0] info);
    logic [14:0] r;
    r = '0;
    for (int i = 0; i < 5; i++) if (info[i]) r = r ^ (15'h0537 << i);
    return r;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [24:0] act, input logic [24:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic send(input logic [14:0] w);
    expq.push_back(expect_of(w));
    for (int i = 14; i >= 0; i--) begin
      bit_in = w[i];
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    #2;
    obs = {all_zero, syn6, syn5, syn4, syn3, syn2, syn1};
    if (rst) begin
      last_seen = '0;
    end else if (done) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R5 R9 unexpected done", obs, '0);
      end else begin
        want = expq.pop_front();
        chk(obs == want, "R2 R3 R4 R6 R7 frame result", obs, want);
        last_seen = obs;
      end
    end else begin
      chk(obs == last_seen, "R8 hold between done", obs, last_seen);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({done, all_zero, syn6, syn5, syn4, syn3, syn2, syn1} == '0, "R1 reset state",
        {all_zero, syn6, syn5, syn4, syn3, syn2, syn1}, '0);
    rst = 1'b0;
    send(cw(5'b10101));
    send(cw(5'b00010));
    send(cw(5'b10101) ^ 15'h0100);
    send(cw(5'b00010) ^ 15'h4021);
    send(15'h7FFF);
    send(15'h4000);
    send(15'h0001);
    send(15'h1234);
    send(15'h5A5A);
    for (int i = 0; i < 7; i++) begin
      bit_in = i[0];
      @(negedge clk);
    end
    rst = 1'b1;
    @(posedge clk);
    #3;
    chk({done, all_zero, syn6, syn5, syn4, syn3, syn2, syn1} == '0, "R1 R9 mid-frame reset",
        {all_zero, syn6, syn5, syn4, syn3, syn2, syn1}, '0);
    @(negedge clk);
    rst = 1'b0;
    send(15'h6B3C);
    send(cw(5'b11111) ^ 15'h0006);
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R5 every frame raised done", 25'(expq.size()), '0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule